// File: doc/BRIEF.md
# Oversampled UART Receiver

This block turns an asynchronous serial line into bytes. The line idles high. Each character has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Timing comes from an external tick enable that pulses sixteen times per bit period. The same tick also paces the transmit side. The receiver counts these ticks to place each sample at the centre of a bit, and never counts raw clock cycles for bit timing.

The raw pin first passes through a two-flop synchronizer. A falling edge on the synchronized line starts a frame and clears the tick counter. The start bit is checked at its centre, and a start bit that has already returned high there is treated as noise. After the stop bit is sampled at its centre, the receiver begins watching for the next falling edge straight away.

A good byte goes into a single holding register, which is offered to the consumer on a ready/valid pair. A stop bit sampled low, or a byte that completes while the holding register is still occupied, raises a one-cycle flag.

Top module: `uart_rx_os`

## Requirements
- R1: All bit timing counts `tick_en` pulses and never raw clocks. With sixteen ticks per bit, a frame whose bit length in clocks is doubled is received correctly once the tick spacing is doubled.
- R2: The pin passes through two flip-flops that reset to 1. After reset, `out_valid`, `frame_err`, `overrun` and `out_data` are all 0.
- R3: A frame begins only when the synchronized line falls from 1 to 0. The tick counter is cleared at that edge, so the sample points follow the observed edge.
- R4: The start bit is sampled after 8 ticks. If the line is high at that point, the receiver returns to idle with no byte and no flag. A later valid frame is still received.
- R5: Eight data bits are sampled 16 ticks apart. Sample i (i = 0 first) is placed in `out_data[i]`.
- R6: The stop bit is sampled 16 ticks after the last data bit. If it is 1, the byte is delivered with `out_valid` high.
- R7: A stop bit sampled as 0 discards the byte and drives `frame_err` high for exactly one clock.
- R8: Right after the stop-bit sample, the receiver watches for a new falling edge. A start bit that begins about 44/64 of the way through the stop bit is received.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. A transfer happens on a clock edge where both are high, and `out_valid` then drops unless a new byte loads on that same edge.
- R10: A byte that completes while `out_valid` is high and `out_ready` is low is dropped. The held byte is unchanged, and `overrun` is high for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_pin | input | 1 | Asynchronous serial input, idle high |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Holding register occupied |
| out_ready | input | 1 | Consumer accepts the byte |
| frame_err | output | 1 | One-cycle pulse: stop bit read as 0 |
| overrun | output | 1 | One-cycle pulse: byte lost, register full |

## Verification
The hardest case to reach is a stop bit cut short, with the next start bit arriving just after the stop-bit centre. Reaching it needs the sample instant known to within a few clocks. The stimulus uses a fixed tick spacing of four clocks. The bit edges are driven on a clock grid, so the sample falls 31 to 35 clocks into each 64-clock bit, and the stop bit is shortened to 44 clocks. Overrun is reached by holding `out_ready` low across two full frames. A glitch is reached with a low pulse shorter than half a bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  // true on the last tick count of a span of the given length
  function automatic bit at_span_end(input int unsigned cnt, input int unsigned span);
    return cnt == span - 1;
  endfunction

  // ticks from the falling edge to the start-bit centre
  function automatic int unsigned start_span(input int unsigned oversample);
    return oversample / 2;
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              line_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain     <= '1;
      line_prev <= 1'b1;
    end else begin
      chain     <= {chain[STAGES-2:0], pin};
      line_prev <= chain[STAGES-1];
    end
  end

  assign line = chain[STAGES-1];
  assign fall = line_prev & ~line;

  // R3
  fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fall |-> $past(line) && !line);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 fall,
  output logic                 done,
  output logic                 stop_ok,
  output logic [DATA_BITS-1:0] data
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(DATA_BITS);

  rx_state_t           st;
  logic [CW-1:0]       tcnt;
  logic [BW-1:0]       bidx;
  logic [DATA_BITS-1:0] shreg;
  logic                start_mid, bit_mid, glitch;

  assign start_mid = tick && (st == RX_START) && at_span_end(int'(tcnt), start_span(OVERSAMPLE));
  assign bit_mid   = tick && (st == RX_DATA || st == RX_STOP) && at_span_end(int'(tcnt), OVERSAMPLE);
  assign glitch    = start_mid && line;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
    end else begin
      unique case (st)
        RX_IDLE: if (fall) begin
          st   <= RX_START;
          tcnt <= '0;
        end
        RX_START: if (start_mid) begin
          tcnt <= '0;
          bidx <= '0;
          st   <= glitch ? RX_IDLE : RX_DATA;
        end else if (tick) tcnt <= tcnt + 1'b1;
        RX_DATA: if (bit_mid) begin
          tcnt  <= '0;
          shreg <= {line, shreg[DATA_BITS-1:1]};
          bidx  <= bidx + 1'b1;
          if (bidx == BW'(DATA_BITS - 1)) st <= RX_STOP;
        end else if (tick) tcnt <= tcnt + 1'b1;
        RX_STOP: if (bit_mid) begin
          tcnt <= '0;
          st   <= RX_IDLE;
        end else if (tick) tcnt <= tcnt + 1'b1;
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign done    = bit_mid && (st == RX_STOP);
  assign stop_ok = line;
  assign data    = shreg;

  // R1
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && st != RX_IDLE) |=> $stable(tcnt) && $stable(st));
  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == RX_START && st == RX_DATA) |-> !$past(line));
  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> st == RX_IDLE);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 stop_ok,
  input  logic [DATA_BITS-1:0] din,
  input  logic                 ready,
  output logic                 valid,
  output logic [DATA_BITS-1:0] dout,
  output logic                 ferr,
  output logic                 ovr
);
  logic accept, space;

  assign accept = load && stop_ok;
  assign space  = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      ferr <= load && !stop_ok;
      ovr  <= accept && !space;
      if (accept && space) begin
        valid <= 1'b1;
        dout  <= din;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> valid && $stable(dout));
  // R7
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ferr |=> !ferr);
  // R10
  overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ovr |-> valid && $stable(dout));
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 rx_pin,
  output logic [DATA_BITS-1:0] out_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 frame_err,
  output logic                 overrun
);
  logic                 line, fall, done, stop_ok;
  logic [DATA_BITS-1:0] data;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(rx_pin), .line(line), .fall(fall)
  );

  uart_rx_frame #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk(clk), .rst(rst), .tick(tick_en), .line(line), .fall(fall),
    .done(done), .stop_ok(stop_ok), .data(data)
  );

  uart_rx_hold #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk(clk), .rst(rst), .load(done), .stop_ok(stop_ok), .din(data),
    .ready(out_ready), .valid(out_valid), .dout(out_data),
    .ferr(frame_err), .ovr(overrun)
  );

  // R10
  ovr_full_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(out_valid) && !$past(out_ready));
endmodule

// File: tb/uart_rx_os_test.sv
`timescale 1ns/1ps
module uart_rx_os_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       rx_pin = 1'b1;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_valid, frame_err, overrun;

  int n_chk = 0, n_fail = 0;
  int tick_div = 4, tcount = 0;
  int nrx = 0, nfe = 0, novr = 0, run_fe = 0, max_fe = 0, run_ov = 0, max_ov = 0;
  logic [7:0] rx_log [0:31];

  // bit 8 = stop value driven, bits 7:0 = byte
  localparam logic [8:0] VEC [6] = '{9'h100, 9'h1FF, 9'h1A5, 9'h03C, 9'h101, 9'h180};

  uart_rx_os uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rx_pin(rx_pin),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .frame_err(frame_err), .overrun(overrun)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tcount++;
    tick_en = (tcount % tick_div) == 0;
  end

  initial forever begin
    @(negedge clk); #1;
    if (out_valid && out_ready && nrx < 32) begin rx_log[nrx] = out_data; nrx++; end
    if (frame_err) begin if (run_fe == 0) nfe++; run_fe++; if (run_fe > max_fe) max_fe = run_fe; end
    else run_fe = 0;
    if (overrun) begin if (run_ov == 0) novr++; run_ov++; if (run_ov > max_ov) max_ov = run_ov; end
    else run_ov = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int n);
    rx_pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop, input int stop_len);
    int blen;
    blen = 16 * tick_div;
    drive_bit(1'b0, blen);
    for (int i = 0; i < 8; i++) drive_bit(b[i], blen);
    drive_bit(stop, stop_len);
    rx_pin = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r0, f0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R2 valid after reset", int'(out_valid), 0);
    chk(frame_err == 1'b0, "R2 frame_err after reset", int'(frame_err), 0);
    chk(overrun == 1'b0, "R2 overrun after reset", int'(overrun), 0);
    chk(out_data == 8'h00, "R2 data after reset", int'(out_data), 0);
    @(negedge clk);
    drive_bit(1'b1, 40);

    // table walk: R3 R5 R6 R7
    out_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      r0 = nrx; f0 = nfe;
      send(VEC[k][7:0], VEC[k][8], 64);
      drive_bit(1'b1, 64);
      if (VEC[k][8]) begin
        chk(nrx == r0 + 1, "R6 byte delivered", nrx - r0, 1);
        chk(rx_log[r0] == VEC[k][7:0], "R5 data bits", int'(rx_log[r0]), int'(VEC[k][7:0]));
        chk(nfe == f0, "R6 no frame error", nfe - f0, 0);
      end else begin
        chk(nrx == r0, "R7 byte discarded", nrx - r0, 0);
        chk(nfe == f0 + 1, "R7 frame_err raised", nfe - f0, 1);
      end
    end
    chk(max_fe == 1, "R7 frame_err width", max_fe, 1);

    // R4 glitch shorter than half a bit
    r0 = nrx; f0 = nfe;
    drive_bit(1'b0, 12);
    drive_bit(1'b1, 200);
    chk(nrx == r0 && out_valid == 1'b0, "R4 glitch gives no byte", nrx - r0, 0);
    chk(nfe == f0, "R4 glitch gives no flag", nfe - f0, 0);
    send(8'hC3, 1'b1, 64);
    drive_bit(1'b1, 64);
    chk(nrx == r0 + 1 && rx_log[r0] == 8'hC3, "R4 recovery after glitch", int'(rx_log[r0]), 'hC3);

    // R8 short stop bit, next start right after centre
    r0 = nrx;
    send(8'h96, 1'b1, 44);
    send(8'h69, 1'b1, 64);
    drive_bit(1'b1, 64);
    chk(nrx == r0 + 2, "R8 both frames received", nrx - r0, 2);
    chk(rx_log[r0] == 8'h96 && rx_log[r0+1] == 8'h69, "R8 early hunt data",
        int'({rx_log[r0], rx_log[r0+1]}), 'h9669);

    // R1 doubled tick spacing and doubled bit length
    r0 = nrx;
    tick_div = 8;
    drive_bit(1'b1, 16);
    send(8'h5E, 1'b1, 128);
    drive_bit(1'b1, 128);
    chk(nrx == r0 + 1 && rx_log[r0] == 8'h5E, "R1 tick-paced timing", int'(rx_log[r0]), 'h5E);
    tick_div = 4;
    drive_bit(1'b1, 16);

    // R9 and R10 hold with ready low, then overrun
    r0 = nrx;
    out_ready = 1'b0;
    send(8'h11, 1'b1, 64);
    drive_bit(1'b1, 64);
    chk(out_valid == 1'b1 && out_data == 8'h11, "R9 byte held", int'(out_data), 'h11);
    send(8'h22, 1'b1, 64);
    drive_bit(1'b1, 64);
    chk(out_data == 8'h11 && out_valid == 1'b1, "R10 held byte kept", int'(out_data), 'h11);
    chk(novr == 1 && max_ov == 1, "R10 overrun one pulse", novr * 16 + max_ov, 'h11);
    chk(nrx == r0, "R9 no transfer while not ready", nrx - r0, 0);
    out_ready = 1'b1;
    @(negedge clk); #1;
    chk(nrx == r0 + 1 && rx_log[r0] == 8'h11, "R9 transfer on ready", int'(rx_log[r0]), 'h11);
    chk(out_valid == 1'b0, "R9 valid drops after transfer", int'(out_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule